// File: doc/BRIEF.md
# Network Controller Event and Interrupt Unit

This unit gathers the status pulses produced by the receive, transmit and buffer sections of a small Ethernet-style controller. It latches them into three clear-on-read event registers and keeps two 10-bit error counters, one for receive frames that were missed and one for transmit collisions. From these it drives one level-sensitive interrupt line toward the host. Configuration registers decide which latched conditions may raise that line.

For each received frame, the receive logic presents a status vector made of four classes: good frame, CRC error, runt and extra data. The unit records these classes as receive events. It also decides whether the frame is kept, using a separate set of accept bits. A frame whose class is not accepted is reported with its length forced to zero. The class can still interrupt the host through its own enable.

The host reaches the unit through a simple read/write register port, and read data appears one cycle after the read strobe. Address filtering, the MAC, DMA and buffer memory sit outside this unit.

Top module: `netEventUnit`

## Requirements
- R1: An event bit latches when its event occurs, whatever the state of its interrupt enable. Receive event register (address 0x04): bit0 good, bit1 CRC error, bit2 runt, bit3 extra data. Transmit event register (0x08): bits 5:0 follow `txEvtIn[5:0]`, and bit6 records a collision. Buffer event register (0x0C): bits 3:0 follow `bufEvtIn[3:0]`, and bit4 records a missed frame.
- R2: A host read of an event register returns its contents on `hostRdata` one cycle after the strobe and leaves the register fully cleared.
- R3: An event that arrives in the same cycle as the clearing read of its register is still set after that read.
- R4: `irq` is high exactly when some latched event bit has its enable set, or a counter overflow flag has its enable set. Enable registers use the event bit positions: receive enables at 0x03, transmit at 0x07, buffer at 0x0B. After the host reads the pending registers, `irq` drops.
- R5: The missed-frame counter (0x10) counts `rxMissPulse` cycles, and the collision counter (0x12) counts `txColPulse` cycles. Each collision also sets transmit event bit6, so the collision interrupt fires on every increment. A counter reads as count in bits 9:0 and clears on read.
- R6: When a counter steps from 0x1FF to 0x200, its overflow flag (read bit15) sets. The flag interrupts through buffer enable bit5 (missed) or bit6 (collision). The count wraps from 0x3FF to 0. The flag stays set until the counter is read.
- R7: The frame decision appears one cycle after `frmValid`, with `frmAcceptVld` high. A frame is accepted only if every status class it carries has its accept bit set in the control register (0x05, same bit order as the receive events). A rejected frame reports `frmLenOut` = 0, and an accepted one reports `frmLen`.
- R8: Receive events are recorded from the frame status whether or not the frame is accepted. An enabled but unaccepted class therefore interrupts and still rejects the frame.
- R9: Host writes change only the configuration and control registers, which read back their implemented bits. Writes to event or counter addresses change nothing.
- R10: After reset all registers and counters are zero, `irq` is low and `frmAcceptVld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostRd | input | 1 | Host read strobe |
| hostWr | input | 1 | Host write strobe |
| hostAddr | input | 5 | Register address |
| hostWdata | input | 16 | Write data |
| hostRdata | output | 16 | Read data, valid the cycle after the strobe |
| irq | output | 1 | Level host interrupt |
| rxMissPulse | input | 1 | One missed receive frame per cycle high |
| txColPulse | input | 1 | One transmit collision per cycle high |
| txEvtIn | input | 6 | Other transmit event pulses |
| bufEvtIn | input | 4 | Buffer event pulses |
| frmValid | input | 1 | Frame status present |
| frmStatus | input | 4 | Frame class bits |
| frmLen | input | 11 | Frame length |
| frmAcceptVld | output | 1 | Decision valid |
| frmAccept | output | 1 | Frame kept |
| frmLenOut | output | 11 | Reported length, zero when rejected |

## Verification
The hardest conditions to reach from the ports are the counter overflow and the wrap that follows it. The first needs 512 increments with no intervening read, and the second needs 1024. The stimulus holds `txColPulse` or `rxMissPulse` high for long unbroken runs. It then observes `irq` right at the 0x1FF to 0x200 step, and reads the counter only after the wrap, so that the sticky flag can be seen beside a zero count. The collision between a clearing read and a new event is produced by raising `hostRd` and `frmValid` in one cycle.

// File: rtl/netEvtPkg.sv
package netEvtPkg;
  localparam int ADR_W = 5;

  localparam logic [ADR_W-1:0] ADR_RXCFG  = 5'h03;
  localparam logic [ADR_W-1:0] ADR_RXEVT  = 5'h04;
  localparam logic [ADR_W-1:0] ADR_RXCTL  = 5'h05;
  localparam logic [ADR_W-1:0] ADR_TXCFG  = 5'h07;
  localparam logic [ADR_W-1:0] ADR_TXEVT  = 5'h08;
  localparam logic [ADR_W-1:0] ADR_BUFCFG = 5'h0B;
  localparam logic [ADR_W-1:0] ADR_BUFEVT = 5'h0C;
  localparam logic [ADR_W-1:0] ADR_MISS   = 5'h10;
  localparam logic [ADR_W-1:0] ADR_COL    = 5'h12;

  // strobes from the control decoder into the datapath
  typedef struct packed {
    logic rdRx;
    logic rdTx;
    logic rdBuf;
    logic rdMiss;
    logic rdCol;
    logic rdRxCfg;
    logic rdRxCtl;
    logic rdTxCfg;
    logic rdBufCfg;
    logic wrRxCfg;
    logic wrRxCtl;
    logic wrTxCfg;
    logic wrBufCfg;
  } hostStb_t;
endpackage

// File: rtl/evtCtrl.sv
module evtCtrl
  import netEvtPkg::*;
(
  input  logic             hostRd,
  input  logic             hostWr,
  input  logic [ADR_W-1:0] hostAddr,
  output hostStb_t         stb
);
  always_comb begin
    stb = '0;
    if (hostRd) begin
      case (hostAddr)
        ADR_RXEVT:  stb.rdRx     = 1'b1;
        ADR_TXEVT:  stb.rdTx     = 1'b1;
        ADR_BUFEVT: stb.rdBuf    = 1'b1;
        ADR_MISS:   stb.rdMiss   = 1'b1;
        ADR_COL:    stb.rdCol    = 1'b1;
        ADR_RXCFG:  stb.rdRxCfg  = 1'b1;
        ADR_RXCTL:  stb.rdRxCtl  = 1'b1;
        ADR_TXCFG:  stb.rdTxCfg  = 1'b1;
        ADR_BUFCFG: stb.rdBufCfg = 1'b1;
        default: ;
      endcase
    end
    // event and counter addresses have no write strobe (R9)
    if (hostWr) begin
      case (hostAddr)
        ADR_RXCFG:  stb.wrRxCfg  = 1'b1;
        ADR_RXCTL:  stb.wrRxCtl  = 1'b1;
        ADR_TXCFG:  stb.wrTxCfg  = 1'b1;
        ADR_BUFCFG: stb.wrBufCfg = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/evtCounter.sv
module evtCounter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] HALF_MAX = {1'b0, {(CNT_W-1){1'b1}}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (clr) begin
      // a step in the read cycle starts the fresh count
      cnt <= {{(CNT_W-1){1'b0}}, inc};
      ovf <= 1'b0;
    end else if (inc) begin
      cnt <= cnt + 1'b1;
      if (cnt == HALF_MAX) ovf <= 1'b1;
    end
  end

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rstN)
    inc && !clr |=> cnt == $past(cnt) + 1'b1);
  a_r5_clear_read: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> cnt == {{(CNT_W-1){1'b0}}, $past(inc)});
  a_r6_ovf_set: assert property (@(posedge clk) disable iff (!rstN)
    inc && !clr && cnt == HALF_MAX |=> ovf);
  a_r6_ovf_hold: assert property (@(posedge clk) disable iff (!rstN)
    ovf && !clr |=> ovf);
endmodule

// File: rtl/evtPath.sv
module evtPath
  import netEvtPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 10,
  parameter int TX_N   = 6,
  parameter int BUF_N  = 4,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStb_t          stb,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              irq,
  input  logic              rxMissPulse,
  input  logic              txColPulse,
  input  logic [TX_N-1:0]   txEvtIn,
  input  logic [BUF_N-1:0]  bufEvtIn,
  input  logic              frmValid,
  input  logic [3:0]        frmStatus,
  input  logic [LEN_W-1:0]  frmLen,
  output logic              frmAcceptVld,
  output logic              frmAccept,
  output logic [LEN_W-1:0]  frmLenOut
);
  localparam int RX_W   = 4;
  localparam int TXE_W  = TX_N + 1;
  localparam int BUFE_W = BUF_N + 1;
  localparam int BCFG_W = BUFE_W + 2;

  logic [RX_W-1:0]   rxCfg, rxCtl, rxEvt, rxSet;
  logic [TXE_W-1:0]  txCfg, txEvt, txSet;
  logic [BCFG_W-1:0] bufCfg;
  logic [BUFE_W-1:0] bufEvt, bufSet;
  logic [CNT_W-1:0]  missCnt, colCnt;
  logic              missOvf, colOvf, frmOk;
  logic [DATA_W-1:0] rdNext;

  assign rxSet  = frmValid ? frmStatus : '0;
  assign txSet  = {txColPulse, txEvtIn};
  assign bufSet = {rxMissPulse, bufEvtIn};
  assign frmOk  = (frmStatus & ~rxCtl) == '0;

  evtCounter #(.CNT_W(CNT_W)) uMiss (
    .clk(clk), .rstN(rstN), .inc(rxMissPulse), .clr(stb.rdMiss),
    .cnt(missCnt), .ovf(missOvf));
  evtCounter #(.CNT_W(CNT_W)) uCol (
    .clk(clk), .rstN(rstN), .inc(txColPulse), .clr(stb.rdCol),
    .cnt(colCnt), .ovf(colOvf));

  // configuration and control
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxCfg  <= '0;
      rxCtl  <= '0;
      txCfg  <= '0;
      bufCfg <= '0;
    end else begin
      if (stb.wrRxCfg)  rxCfg  <= hostWdata[RX_W-1:0];
      if (stb.wrRxCtl)  rxCtl  <= hostWdata[RX_W-1:0];
      if (stb.wrTxCfg)  txCfg  <= hostWdata[TXE_W-1:0];
      if (stb.wrBufCfg) bufCfg <= hostWdata[BCFG_W-1:0];
    end
  end

  // event latches: clear on read, new arrivals survive the read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxEvt  <= '0;
      txEvt  <= '0;
      bufEvt <= '0;
    end else begin
      rxEvt  <= (stb.rdRx  ? '0 : rxEvt)  | rxSet;
      txEvt  <= (stb.rdTx  ? '0 : txEvt)  | txSet;
      bufEvt <= (stb.rdBuf ? '0 : bufEvt) | bufSet;
    end
  end

  always_comb begin
    rdNext = '0;
    if (stb.rdRx)     rdNext[RX_W-1:0]   = rxEvt;
    if (stb.rdTx)     rdNext[TXE_W-1:0]  = txEvt;
    if (stb.rdBuf)    rdNext[BUFE_W-1:0] = bufEvt;
    if (stb.rdRxCfg)  rdNext[RX_W-1:0]   = rxCfg;
    if (stb.rdRxCtl)  rdNext[RX_W-1:0]   = rxCtl;
    if (stb.rdTxCfg)  rdNext[TXE_W-1:0]  = txCfg;
    if (stb.rdBufCfg) rdNext[BCFG_W-1:0] = bufCfg;
    if (stb.rdMiss) begin
      rdNext[CNT_W-1:0]  = missCnt;
      rdNext[DATA_W-1]   = missOvf;
    end
    if (stb.rdCol) begin
      rdNext[CNT_W-1:0]  = colCnt;
      rdNext[DATA_W-1]   = colOvf;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRdata    <= '0;
      frmAcceptVld <= 1'b0;
      frmAccept    <= 1'b0;
      frmLenOut    <= '0;
    end else begin
      hostRdata    <= rdNext;
      frmAcceptVld <= frmValid;
      frmAccept    <= frmValid && frmOk;
      frmLenOut    <= (frmValid && frmOk) ? frmLen : '0;
    end
  end

  assign irq = (|(rxEvt & rxCfg)) | (|(txEvt & txCfg))
             | (|(bufEvt & bufCfg[BUFE_W-1:0]))
             | (missOvf & bufCfg[BUFE_W]) | (colOvf & bufCfg[BUFE_W+1]);

  a_r1_tx_latch: assert property (@(posedge clk) disable iff (!rstN)
    |txSet |=> (txEvt & $past(txSet)) == $past(txSet));
  a_r2_rx_cleared: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdRx && !frmValid |=> rxEvt == '0);
  a_r3_rx_kept: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdRx && frmValid |=> rxEvt == $past(frmStatus));
  a_r7_reject_len: assert property (@(posedge clk) disable iff (!rstN)
    frmAcceptVld && !frmAccept |-> frmLenOut == '0);
  a_r4_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (rxEvt != '0) || (txEvt != '0) || (bufEvt != '0) || missOvf || colOvf);
endmodule

// File: rtl/netEventUnit.sv
module netEventUnit
  import netEvtPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 10,
  parameter int TX_N   = 6,
  parameter int BUF_N  = 4,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [ADR_W-1:0]  hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              irq,
  input  logic              rxMissPulse,
  input  logic              txColPulse,
  input  logic [TX_N-1:0]   txEvtIn,
  input  logic [BUF_N-1:0]  bufEvtIn,
  input  logic              frmValid,
  input  logic [3:0]        frmStatus,
  input  logic [LEN_W-1:0]  frmLen,
  output logic              frmAcceptVld,
  output logic              frmAccept,
  output logic [LEN_W-1:0]  frmLenOut
);
  hostStb_t stb;

  evtCtrl uCtrl (
    .hostRd(hostRd), .hostWr(hostWr), .hostAddr(hostAddr), .stb(stb));

  evtPath #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .TX_N(TX_N), .BUF_N(BUF_N), .LEN_W(LEN_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .irq(irq),
    .rxMissPulse(rxMissPulse), .txColPulse(txColPulse),
    .txEvtIn(txEvtIn), .bufEvtIn(bufEvtIn),
    .frmValid(frmValid), .frmStatus(frmStatus), .frmLen(frmLen),
    .frmAcceptVld(frmAcceptVld), .frmAccept(frmAccept), .frmLenOut(frmLenOut));
endmodule

// File: tb/tb_netEventUnit.sv
`timescale 1ns/1ps
module tb_netEventUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostRd = 1'b0, hostWr = 1'b0;
  logic [4:0]  hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;
  logic        irq;
  logic        rxMissPulse = 1'b0, txColPulse = 1'b0;
  logic [5:0]  txEvtIn = '0;
  logic [3:0]  bufEvtIn = '0;
  logic        frmValid = 1'b0;
  logic [3:0]  frmStatus = '0;
  logic [10:0] frmLen = '0;
  logic        frmAcceptVld, frmAccept;
  logic [10:0] frmLenOut;

  int nChk = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  netEventUnit dut (
    .clk(clk), .rstN(rstN), .hostRd(hostRd), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .irq(irq), .rxMissPulse(rxMissPulse), .txColPulse(txColPulse),
    .txEvtIn(txEvtIn), .bufEvtIn(bufEvtIn), .frmValid(frmValid),
    .frmStatus(frmStatus), .frmLen(frmLen), .frmAcceptVld(frmAcceptVld),
    .frmAccept(frmAccept), .frmLenOut(frmLenOut));

  // {acceptBits, status, len, expAccept, expLen}
  localparam logic [30:0] VEC [6] = '{
    {4'hF, 4'h1, 11'd64,   1'b1, 11'd64},
    {4'h1, 4'h2, 11'd100,  1'b0, 11'd0},
    {4'h2, 4'h2, 11'd100,  1'b1, 11'd100},
    {4'h0, 4'h4, 11'd20,   1'b0, 11'd0},
    {4'hC, 4'h9, 11'd1500, 1'b0, 11'd0},
    {4'h9, 4'h9, 11'd2047, 1'b1, 11'd2047}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); hostRd = 1'b1; hostAddr = a;
    @(negedge clk); hostRd = 1'b0; d = hostRdata;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk); hostWr = 1'b0;
  endtask

  task automatic sendFrame(input logic [3:0] st, input logic [10:0] len);
    @(negedge clk); frmValid = 1'b1; frmStatus = st; frmLen = len;
    @(negedge clk); frmValid = 1'b0;
  endtask

  task automatic pulseCol(input int n);
    @(negedge clk); txColPulse = 1'b1;
    repeat (n) @(negedge clk);
    txColPulse = 1'b0;
  endtask

  task automatic pulseMiss(input int n);
    @(negedge clk); rxMissPulse = 1'b1;
    repeat (n) @(negedge clk);
    rxMissPulse = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [30:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 irq", irq, 0);
    chk("R10 acceptVld", frmAcceptVld, 0);
    rd(5'h12, d); chk("R10 col counter", d, 0);
    rd(5'h03, d); chk("R10 rx enables", d, 0);

    // R7/R8/R2 table walk, enables off so irq stays low (R1)
    foreach (VEC[i]) begin
      v = VEC[i];
      wr(5'h05, {12'h0, v[30:27]});
      sendFrame(v[26:23], v[22:12]);
      chk("R7 accept valid", frmAcceptVld, 1);
      chk("R7 accept", frmAccept, v[11]);
      chk("R7 length", frmLenOut, v[10:0]);
      chk("R1 irq low with enables off", irq, 0);
      rd(5'h04, d); chk("R8 rx events from status", d, {12'h0, v[26:23]});
      rd(5'h04, d); chk("R2 rx events cleared", d, 0);
    end

    // R1/R4 transmit events and the enable gate
    wr(5'h07, 16'h0001);
    @(negedge clk); txEvtIn = 6'h02;
    @(negedge clk); txEvtIn = 6'h00;
    chk("R4 irq off for disabled bit", irq, 0);
    @(negedge clk); txEvtIn = 6'h01;
    @(negedge clk); txEvtIn = 6'h00;
    chk("R4 irq on for enabled bit", irq, 1);
    rd(5'h08, d); chk("R1 tx events both latched", d, 16'h0003);
    chk("R4 irq drops after read", irq, 0);
    wr(5'h07, 16'h0000);

    // R8 interrupt and reject together
    wr(5'h03, 16'h0002);
    wr(5'h05, 16'h0001);
    sendFrame(4'h2, 11'd80);
    chk("R8 rejected", frmAccept, 0);
    chk("R8 length zero", frmLenOut, 0);
    chk("R8 irq raised", irq, 1);
    rd(5'h04, d); chk("R8 crc event", d, 16'h0002);
    chk("R4 irq low after read", irq, 0);
    wr(5'h03, 16'h0000);

    // R3 event in the same cycle as the clearing read
    sendFrame(4'h2, 11'd70);
    @(negedge clk);
    hostRd = 1'b1; hostAddr = 5'h04; frmValid = 1'b1; frmStatus = 4'h1;
    @(negedge clk);
    hostRd = 1'b0; frmValid = 1'b0; d = hostRdata;
    chk("R3 read returns old", d, 16'h0002);
    rd(5'h04, d); chk("R3 new event kept", d, 16'h0001);

    // R5 counters
    wr(5'h07, 16'h0040);
    pulseMiss(3);
    rd(5'h10, d); chk("R5 miss count", d, 3);
    rd(5'h10, d); chk("R5 miss cleared", d, 0);
    rd(5'h0C, d); chk("R5 missed event bit4", d, 16'h0010);
    pulseCol(2);
    chk("R5 collision irq", irq, 1);
    rd(5'h12, d); chk("R5 col count", d, 2);
    rd(5'h08, d); chk("R5 collision event bit6", d, 16'h0040);
    chk("R5 irq low after reads", irq, 0);
    wr(5'h07, 16'h0000);

    // R6 overflow and wrap
    wr(5'h0B, 16'h0040);
    pulseCol(511);
    chk("R6 no overflow at 0x1FF", irq, 0);
    pulseCol(1);
    chk("R6 overflow irq at 0x200", irq, 1);
    pulseCol(512);
    chk("R6 irq held after wrap", irq, 1);
    rd(5'h12, d); chk("R6 wrapped with flag", d, 16'h8000);
    chk("R6 irq low after read", irq, 0);
    rd(5'h12, d); chk("R6 flag cleared", d, 0);
    rd(5'h08, d);
    wr(5'h0B, 16'h0020);
    pulseMiss(512);
    chk("R6 miss overflow irq", irq, 1);
    rd(5'h10, d); chk("R6 miss count and flag", d, 16'h8200);
    chk("R6 miss irq cleared", irq, 0);
    rd(5'h0C, d);
    wr(5'h0B, 16'h0000);

    // R9 writes to event and counter addresses ignored
    wr(5'h04, 16'hFFFF);
    rd(5'h04, d); chk("R9 rx event write ignored", d, 0);
    wr(5'h10, 16'hFFFF);
    rd(5'h10, d); chk("R9 counter write ignored", d, 0);
    wr(5'h03, 16'h000A);
    rd(5'h03, d); chk("R9 rx enable readback", d, 16'h000A);
    wr(5'h0B, 16'hFFFF);
    rd(5'h0B, d); chk("R9 buffer enable readback", d, 16'h007F);
    wr(5'h0B, 16'h0000);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule